// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Controller

This block keeps two equal-size frame buffers between a sample stream and a processor. The stream side writes incoming samples into one buffer. During that time the processor has sole use of the other buffer through a small read/write port. When the stream side has written a whole frame, the two buffers change roles in one clock edge. An interrupt is then raised, so the processor can work on the frame that has just been filled while the next one arrives.

Processor addresses always run from zero to the frame length minus one. The block maps them onto whichever buffer the processor currently owns, and a status bit shows which one that is. The interrupt stays high until it is acknowledged. A frame that completes while the interrupt is still pending sets a sticky overrun flag.

Top module: `pingpong_buf_ctrl`

## Requirements
- R1: After reset, `cpu_bank` is 0, `irq` is 0, `overrun` is 0 and `s_ready` is 1.
- R2: A sample is accepted on a rising edge where `s_valid` and `s_ready` are both 1. Accepted samples go to consecutive indices 0 to FRAME_LEN-1 of the buffer the processor does not own. The index restarts at 0 after every swap.
- R3: On the edge that accepts the FRAME_LEN-th sample of a frame, `cpu_bank` toggles and `irq` becomes 1. `cpu_bank` changes on no other edge.
- R4: In the cycle after the final sample of a frame, `s_ready` is 0. It is 1 again in the cycle after that, and it is 1 at all other times.
- R5: `irq` stays 1 until `irq_ack` is sampled high; it is then 0 from the next cycle. A frame that completes in the same cycle as the acknowledge keeps `irq` at 1.
- R6: `overrun` becomes 1 when a frame completes while `irq` is 1 and `irq_ack` is 0. It then stays 1 until reset.
- R7: When `cpu_wr` is 1, `cpu_wdata` is written at `cpu_addr` of the processor-owned buffer only. Such writes never alter the frame that the stream side is filling.
- R8: `cpu_rdata` shows the word at `cpu_addr` of the processor-owned buffer, one cycle after the address is presented. After an interrupt, addresses 0 to FRAME_LEN-1 return the frame's samples in arrival order.
- R9: Cycles with `s_valid` at 0 accept nothing. Such gaps inside a frame neither advance the index nor end the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Stream sample present |
| s_data | input | DATA_W | Stream sample |
| s_ready | output | 1 | Stream side can accept a sample |
| cpu_addr | input | ADDR_W | Processor word address within its buffer |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, one cycle latency |
| irq | output | 1 | Frame-complete interrupt, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge |
| cpu_bank | output | 1 | Index of the buffer the processor owns |
| overrun | output | 1 | Sticky: a frame completed with the interrupt still pending |

## Verification
The bench uses FRAME_LEN of 8 and DATA_W of 16. With these values a full frame takes only a few cycles, so several swaps fit in a short run: both buffers are filled, and ownership returns to its starting value. The short frame also lets the bench send back-to-back frames without acknowledging, which reaches the overrun case and the acknowledge-during-completion case. The stream is sent with gaps in `s_valid`, and processor writes are made during a fill, so index holding and buffer isolation are both checked.

// File: rtl/pp_pkg.sv
// Package: shared types and constants for the ping-pong buffer controller.
// Assumes exactly two buffers; a bank index is therefore one bit.
package pp_pkg;
    localparam int NUM_BANKS = 2;
    typedef logic bank_sel_t;
endpackage

// File: rtl/pp_bank_ram.sv
// Module: one frame buffer. It has a synchronous write port and a
// combinational read port.
// Assumes the parent never drives two writers into the same bank at once.
module pp_bank_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word when the write strobe is high.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Asynchronous read of the selected word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/pp_fill_ctrl.sv
// Module: stream-side fill sequencer. It counts accepted samples and swaps
// buffer ownership on the final sample of a frame. It then holds ready low
// for one cycle.
// Assumes the stream follows valid/ready rules (a sample moves when both are high).
module pp_fill_ctrl
    import pp_pkg::*;
#(
    parameter int FRAME_LEN = 8,
    localparam int AW       = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    output logic          s_ready,
    output logic          beat,
    output logic [AW-1:0] wr_idx,
    output logic          frame_done,
    output bank_sel_t     cpu_bank,
    output bank_sel_t     dma_bank
);
    localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_LEN - 1);

    logic swap_hold;

    assign s_ready    = ~swap_hold;
    assign beat       = s_valid & s_ready;
    assign frame_done = beat & (wr_idx == LAST_IDX);
    assign dma_bank   = ~cpu_bank;

    // Advance the index, and swap owners on the closing sample of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx    <= '0;
            cpu_bank  <= 1'b0;
            swap_hold <= 1'b0;
        end else begin
            swap_hold <= frame_done;
            if (frame_done) begin
                wr_idx   <= '0;
                cpu_bank <= ~cpu_bank;
            end else if (beat) begin
                wr_idx <= wr_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pp_irq_ctrl.sv
// Module: interrupt latch with acknowledge, plus a sticky overrun flag.
// Assumes frame_done is a one-cycle pulse per completed frame.
module pp_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    input  logic irq_ack,
    output logic irq,
    output logic overrun
);
    // Set on frame completion (this wins over acknowledge); clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (frame_done)   irq <= 1'b1;
            else if (irq_ack) irq <= 1'b0;
            if (frame_done && irq && !irq_ack) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/pingpong_buf_ctrl.sv
// Module: top of the ping-pong buffer controller. It routes stream writes to
// the stream-owned bank and processor accesses to the processor-owned bank,
// and it registers processor read data.
// Assumes FRAME_LEN >= 2; processor addresses at or above FRAME_LEN are not used.
module pingpong_buf_ctrl
    import pp_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FRAME_LEN = 8,
    localparam int ADDR_W   = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq,
    input  logic              irq_ack,
    output logic              cpu_bank,
    output logic              overrun
);
    logic              beat;
    logic              frame_done;
    logic [ADDR_W-1:0] wr_idx;
    bank_sel_t         own_cpu;
    bank_sel_t         own_dma;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    pp_fill_ctrl #(.FRAME_LEN(FRAME_LEN)) u_fill (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .beat(beat), .wr_idx(wr_idx), .frame_done(frame_done),
        .cpu_bank(own_cpu), .dma_bank(own_dma)
    );

    pp_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .irq_ack(irq_ack), .irq(irq), .overrun(overrun)
    );

    assign cpu_bank = own_cpu;

    // One buffer per bank; the owner of each bank selects its write source.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic              we;
        logic              dma_sel;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;

        assign dma_sel = (own_dma == 1'(g));
        assign we      = dma_sel ? beat : (cpu_wr & (own_cpu == 1'(g)));
        assign waddr   = dma_sel ? wr_idx : cpu_addr;
        assign wdata   = dma_sel ? s_data : cpu_wdata;

        pp_bank_ram #(.DATA_W(DATA_W), .DEPTH(FRAME_LEN)) u_ram (
            .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
            .raddr(cpu_addr), .rdata(bank_rd[g])
        );
    end

    // Register the processor read from the bank it currently owns.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_rdata <= '0;
        else        cpu_rdata <= bank_rd[own_cpu];
    end
endmodule

// File: rtl/pp_chk.sv
// Module: checker for the ping-pong buffer controller. It keeps its own count
// of accepted samples to find frame ends.
// Assumes the same FRAME_LEN as the design it is bound to.
module pp_chk #(
    parameter int FRAME_LEN = 8,
    localparam int CW       = $clog2(FRAME_LEN)
) (
    input logic clk,
    input logic rst_n,
    input logic s_valid,
    input logic s_ready,
    input logic irq,
    input logic irq_ack,
    input logic cpu_bank,
    input logic overrun
);
    logic [CW-1:0] n_seen;
    logic          acc;
    logic          closing;

    assign acc     = s_valid & s_ready;
    assign closing = acc & (n_seen == CW'(FRAME_LEN - 1));

    // Independent count of accepted samples within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       n_seen <= '0;
        else if (closing) n_seen <= '0;
        else if (acc)     n_seen <= n_seen + 1'b1;
    end

    // R3
    swap_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        closing |=> (irq && cpu_bank != $past(cpu_bank)));
    // R3
    bank_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !closing |=> $stable(cpu_bank));
    // R4
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        closing |=> !s_ready);
    // R4
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready |=> s_ready);
    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !closing) |=> !irq);
    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && irq && !irq_ack) |=> overrun);
    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind pingpong_buf_ctrl pp_chk #(.FRAME_LEN(FRAME_LEN)) u_pp_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .irq(irq), .irq_ack(irq_ack), .cpu_bank(cpu_bank), .overrun(overrun)
);

// File: tb/tb_pingpong_buf_ctrl.sv
// Bench: directed scenarios for the ping-pong buffer controller.
module tb_pingpong_buf_ctrl;
    localparam int DW = 16;
    localparam int FL = 8;
    localparam int AW = $clog2(FL);

    logic          clk = 0;
    logic          rst_n = 0;
    logic          s_valid = 0;
    logic [DW-1:0] s_data = '0;
    logic          s_ready;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_wr = 0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          irq;
    logic          irq_ack = 0;
    logic          cpu_bank;
    logic          overrun;

    int n_checks = 0;
    int n_errs   = 0;

    pingpong_buf_ctrl #(.DATA_W(DW), .FRAME_LEN(FL)) dut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .irq_ack(irq_ack), .cpu_bank(cpu_bank), .overrun(overrun)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one sample; returns after the accepting edge.
    task automatic push(input logic [DW-1:0] d);
        @(negedge clk);
        s_valid = 1; s_data = d;
        while (!s_ready) @(negedge clk);
        @(posedge clk);
        #1 s_valid = 0;
    endtask

    // Send a frame whose samples are base+i; gap inserts idle cycles between samples.
    task automatic send_frame(input logic [DW-1:0] base, input int gap);
        for (int i = 0; i < FL; i++) begin
            push(base + DW'(i));
            for (int k = 0; k < gap; k++) @(negedge clk);
        end
    endtask

    task automatic cpu_read(input int a, output logic [DW-1:0] v);
        @(negedge clk);
        cpu_addr = AW'(a);
        @(negedge clk);
        v = cpu_rdata;
    endtask

    task automatic cpu_write(input int a, input logic [DW-1:0] v);
        @(negedge clk);
        cpu_addr = AW'(a); cpu_wdata = v; cpu_wr = 1;
        @(negedge clk);
        cpu_wr = 0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1;
        @(negedge clk);
        irq_ack = 0;
    endtask

    task automatic verify_frame(input logic [DW-1:0] base, input string req);
        logic [DW-1:0] v;
        for (int i = 0; i < FL; i++) begin
            cpu_read(i, v);
            check(v == base + DW'(i), req, v, base + DW'(i));
        end
    endtask

    task automatic t_reset();
        // R1
        check(cpu_bank == 0, "R1 cpu_bank", cpu_bank, 0);
        check(irq == 0, "R1 irq", irq, 0);
        check(overrun == 0, "R1 overrun", overrun, 0);
        check(s_ready == 1, "R1 s_ready", s_ready, 1);
    endtask

    task automatic t_first_frame();
        // R2 R3 R4 R8: gapless frame, then inspect swap, ready gap and contents
        send_frame(16'h1000, 0);
        @(negedge clk);
        check(s_ready == 0, "R4 ready low after last", s_ready, 0);
        check(irq == 1, "R3 irq raised", irq, 1);
        check(cpu_bank == 1, "R3 bank toggled", cpu_bank, 1);
        @(negedge clk);
        check(s_ready == 1, "R4 ready back", s_ready, 1);
        verify_frame(16'h1000, "R8 frame1 readback");
        check(irq == 1, "R5 irq held", irq, 1);
        ack();
        check(irq == 0, "R5 irq cleared", irq, 0);
    endtask

    task automatic t_gaps_and_isolation();
        logic [DW-1:0] v;
        // R9: partial frame with gaps must not swap
        for (int i = 0; i < FL - 1; i++) begin
            push(16'h2000 + DW'(i));
            @(negedge clk); @(negedge clk);
        end
        check(irq == 0, "R9 no irq mid-frame", irq, 0);
        check(cpu_bank == 1, "R9 no swap mid-frame", cpu_bank, 1);
        // R7: processor scribbles over its own buffer during the fill
        for (int i = 0; i < FL; i++) cpu_write(i, 16'hBEEF ^ DW'(i));
        cpu_read(3, v);
        check(v == (16'hBEEF ^ 16'd3), "R7 cpu write readback", v, 16'hBEEF ^ 16'd3);
        push(16'h2000 + DW'(FL - 1));
        @(negedge clk);
        check(cpu_bank == 0, "R3 second swap", cpu_bank, 0);
        verify_frame(16'h2000, "R7 R9 frame2 intact");
        ack();
    endtask

    task automatic t_overrun();
        // R6: two frames with no acknowledge
        send_frame(16'h3000, 0);
        @(negedge clk);
        check(overrun == 0, "R6 no overrun after one", overrun, 0);
        send_frame(16'h4000, 1);
        @(negedge clk);
        check(overrun == 1, "R6 overrun set", overrun, 1);
        check(cpu_bank == 0, "R3 bank after two swaps", cpu_bank, 0);
        verify_frame(16'h4000, "R2 latest frame visible");
        ack();
        check(irq == 0, "R5 cleared after overrun", irq, 0);
        check(overrun == 1, "R6 overrun sticky", overrun, 1);
    endtask

    task automatic t_ack_same_cycle();
        // R5: acknowledge in the same cycle as frame completion keeps irq high
        send_frame(16'h5000, 0);
        ack();
        for (int i = 0; i < FL - 1; i++) push(16'h6000 + DW'(i));
        @(negedge clk);
        s_valid = 1; s_data = 16'h6000 + DW'(FL - 1); irq_ack = 1;
        @(negedge clk);
        s_valid = 0; irq_ack = 0;
        check(irq == 1, "R5 completion beats ack", irq, 1);
        verify_frame(16'h6000, "R8 frame after ack race");
        ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_first_frame();
        t_gaps_and_isolation();
        t_overrun();
        t_ack_same_cycle();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule